// File: doc/BRIEF.md
# Shift Enable Router for a Two-Dimensional Filter

This block turns the two shift-enable controls of a two-dimensional image filter into separate load strobes. One control belongs to the horizontal filter and one to the vertical filter. It also takes a cascade-mode field and one option bit per limit register. From these it drives five load strobes:

- the input register,
- the horizontal forward/reverse delay registers,
- the vertical line buffers,
- the horizontal limit register,
- the vertical limit register.

The filter datapaths sit outside this block and only take the strobes.

Both shift controls are active low. A strobe that is low tells its register group to keep its contents. The strobes are registered once, so each one reflects the controls sampled at the previous rising edge. The cascade mode decides which shift control gates which group:

- The filter that comes first in the cascade owns the input register.
- In orthogonal mode, the data groups need both controls at once.
- A limit register placed "under shift control" follows the shift control of the filter on the other side of the cascade.

Top module: `shift_enable_router`

## Requirements
- R1: A synchronous active-high reset drives all five load strobes low. Each strobe is registered, so it reflects the controls sampled at the previous rising edge.
- R2: In separate mode (`mode` = 2'b00), the input register strobe is high every cycle.
- R3: In horizontal-feeds-vertical mode (`mode` = 2'b01), the input register strobe is high exactly when `h_shift_n` was low.
- R4: In vertical-feeds-horizontal mode (`mode` = 2'b10), the input register strobe is high exactly when `v_shift_n` was low.
- R5: In vertical-feeds-horizontal mode with `vlim_on_shift` high, the vertical limit strobe is high exactly when `h_shift_n` was low.
- R6: In horizontal-feeds-vertical mode with `hlim_on_shift` high, the horizontal limit strobe is high exactly when `v_shift_n` was low.
- R7: In orthogonal mode (`mode` = 2'b11), the input, horizontal delay and line buffer strobes are high only when both `h_shift_n` and `v_shift_n` were low. Either control alone blocks them.
- R8: In orthogonal mode, both limit strobes are high every cycle, whatever the option bits.
- R9: Outside orthogonal mode, a limit strobe that R5 or R6 does not gate is high every cycle.
- R10: Outside orthogonal mode, the horizontal delay strobe is high exactly when `h_shift_n` was low, and the line buffer strobe is high exactly when `v_shift_n` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| h_shift_n | input | 1 | Horizontal shift enable, active low |
| v_shift_n | input | 1 | Vertical shift enable, active low |
| mode | input | 2 | Cascade mode: 00 separate, 01 H feeds V, 10 V feeds H, 11 orthogonal |
| hlim_on_shift | input | 1 | Horizontal limit register follows the vertical shift control in mode 01 |
| vlim_on_shift | input | 1 | Vertical limit register follows the horizontal shift control in mode 10 |
| in_load | output | 1 | Input register load strobe |
| hdly_load | output | 1 | Horizontal forward/reverse delay register load strobe |
| vbuf_load | output | 1 | Vertical line buffer load strobe |
| hlim_load | output | 1 | Horizontal limit register load strobe |
| vlim_load | output | 1 | Vertical limit register load strobe |

## Verification
The hardest cases to reach are the cross-gated limit strobes. One such case is the vertical limit strobe following the horizontal control, which needs mode 10, its option bit set and that control toggling. The mirrored case is the horizontal limit strobe following the vertical control. A second hard case is orthogonal mode with exactly one control active, where a strobe must stay low even though its own control asks to load. The stimulus sweeps every combination of mode, both controls and both option bits, one combination per clock. Each combination is held for one edge and the five strobes are compared on the next half cycle, so a leftover value from the previous combination would show up as a mismatch.

// File: rtl/shift_router_pkg.sv
package shift_router_pkg;

  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    CASC_SEPARATE = 2'b00,
    CASC_H_TO_V   = 2'b01,
    CASC_V_TO_H   = 2'b10,
    CASC_ORTHO    = 2'b11
  } casc_mode_e;

  localparam int NUM_LOADS = 5;

  typedef struct packed {
    logic in_ld;
    logic hdly_ld;
    logic vbuf_ld;
    logic hlim_ld;
    logic vlim_ld;
  } load_vec_t;

endpackage

// File: rtl/shift_data_decode.sv
module shift_data_decode
  import shift_router_pkg::*;
(
  input  logic       h_act,
  input  logic       v_act,
  input  casc_mode_e mode,
  output logic       in_ld,
  output logic       hdly_ld,
  output logic       vbuf_ld
);

  logic both_act;
  assign both_act = h_act & v_act;

  always_comb begin
    hdly_ld = h_act;
    vbuf_ld = v_act;
    unique case (mode)
      CASC_SEPARATE: in_ld = 1'b1;
      CASC_H_TO_V:   in_ld = h_act;
      CASC_V_TO_H:   in_ld = v_act;
      CASC_ORTHO: begin
        in_ld   = both_act;
        hdly_ld = both_act;
        vbuf_ld = both_act;
      end
      default:       in_ld = 1'b1;
    endcase
  end

endmodule

// File: rtl/shift_limit_gate.sv
module shift_limit_gate
  import shift_router_pkg::*;
#(
  parameter logic [MODE_W-1:0] GATED_MODE = 2'b01
) (
  input  casc_mode_e mode,
  input  logic       on_shift,
  input  logic       far_act,
  output logic       lim_ld
);

  always_comb begin
    if (mode == casc_mode_e'(GATED_MODE) && on_shift)
      lim_ld = far_act;
    else
      lim_ld = 1'b1;
  end

endmodule

// File: rtl/shift_load_reg.sv
module shift_load_reg #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

endmodule

// File: rtl/shift_enable_router.sv
module shift_enable_router
  import shift_router_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       h_shift_n,
  input  logic       v_shift_n,
  input  logic [1:0] mode,
  input  logic       hlim_on_shift,
  input  logic       vlim_on_shift,
  output logic       in_load,
  output logic       hdly_load,
  output logic       vbuf_load,
  output logic       hlim_load,
  output logic       vlim_load
);

  localparam int NUM_LIM = 2;

  casc_mode_e mode_e;
  logic       h_act, v_act;
  load_vec_t  nxt, cur;

  logic [NUM_LIM-1:0] lim_opt, lim_far, lim_ld;

  assign mode_e = casc_mode_e'(mode);
  assign h_act  = ~h_shift_n;
  assign v_act  = ~v_shift_n;

  shift_data_decode u_data (
    .h_act   (h_act),
    .v_act   (v_act),
    .mode    (mode_e),
    .in_ld   (nxt.in_ld),
    .hdly_ld (nxt.hdly_ld),
    .vbuf_ld (nxt.vbuf_ld)
  );

  // index 0: horizontal limit (gated by vertical control in H->V)
  // index 1: vertical limit (gated by horizontal control in V->H)
  assign lim_opt = {vlim_on_shift, hlim_on_shift};
  assign lim_far = {h_act, v_act};

  for (genvar g = 0; g < NUM_LIM; g++) begin : g_lim
    localparam logic [MODE_W-1:0] GM = (g == 0) ? CASC_H_TO_V : CASC_V_TO_H;
    shift_limit_gate #(.GATED_MODE(GM)) u_gate (
      .mode     (mode_e),
      .on_shift (lim_opt[g]),
      .far_act  (lim_far[g]),
      .lim_ld   (lim_ld[g])
    );
  end

  assign nxt.hlim_ld = lim_ld[0];
  assign nxt.vlim_ld = lim_ld[1];

  shift_load_reg #(.W(NUM_LOADS)) u_reg (
    .clk (clk),
    .rst (rst),
    .d   (nxt),
    .q   (cur)
  );

  assign in_load   = cur.in_ld;
  assign hdly_load = cur.hdly_ld;
  assign vbuf_load = cur.vbuf_ld;
  assign hlim_load = cur.hlim_ld;
  assign vlim_load = cur.vlim_ld;

endmodule

// File: rtl/shift_enable_router_chk.sv
module shift_enable_router_chk (
  input logic       clk,
  input logic       rst,
  input logic       h_shift_n,
  input logic       v_shift_n,
  input logic [1:0] mode,
  input logic       hlim_on_shift,
  input logic       vlim_on_shift,
  input logic       in_load,
  input logic       hdly_load,
  input logic       vbuf_load,
  input logic       hlim_load,
  input logic       vlim_load
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !(in_load | hdly_load | vbuf_load | hlim_load | vlim_load));

  // R7
  ortho_block_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) == 2'b11 && $past(h_shift_n | v_shift_n))
      |-> !(in_load | hdly_load | vbuf_load));

  // R8
  ortho_limits_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) == 2'b11) |-> (hlim_load && vlim_load));

  // R5
  vlim_cross_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) == 2'b10 && $past(vlim_on_shift))
      |-> (vlim_load == !$past(h_shift_n)));

  // R6
  hlim_cross_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) == 2'b01 && $past(hlim_on_shift))
      |-> (hlim_load == !$past(v_shift_n)));

  // R10
  hdly_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) != 2'b11)
      |-> (hdly_load == !$past(h_shift_n) && vbuf_load == !$past(v_shift_n)));

  // R2
  sep_input_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) == 2'b00) |-> in_load);

endmodule

bind shift_enable_router shift_enable_router_chk u_chk (.*);

// File: tb/shift_enable_router_bench.sv
module shift_enable_router_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       h_shift_n = 1'b1;
  logic       v_shift_n = 1'b1;
  logic [1:0] mode = 2'b00;
  logic       hlim_on_shift = 1'b0;
  logic       vlim_on_shift = 1'b0;
  logic       in_load, hdly_load, vbuf_load, hlim_load, vlim_load;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  shift_enable_router u_shift_enable_router (
    .clk           (clk),
    .rst           (rst),
    .h_shift_n     (h_shift_n),
    .v_shift_n     (v_shift_n),
    .mode          (mode),
    .hlim_on_shift (hlim_on_shift),
    .vlim_on_shift (vlim_on_shift),
    .in_load       (in_load),
    .hdly_load     (hdly_load),
    .vbuf_load     (vbuf_load),
    .hlim_load     (hlim_load),
    .vlim_load     (vlim_load)
  );

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b (mode=%b hn=%b vn=%b ho=%b vo=%b)",
               tag, what, act, exp, mode, h_shift_n, v_shift_n, hlim_on_shift, vlim_on_shift);
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state with every input pushing towards loading
    h_shift_n = 1'b0;
    v_shift_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "in_load",   in_load,   1'b0);
    check("R1", "hdly_load", hdly_load, 1'b0);
    check("R1", "vbuf_load", vbuf_load, 1'b0);
    check("R1", "hlim_load", hlim_load, 1'b0);
    check("R1", "vlim_load", vlim_load, 1'b0);
    rst = 1'b0;

    for (int k = 0; k < 64; k++) begin
      logic [1:0] m;
      logic hn, vn, ho, vo, ha, va;
      logic e_in, e_hd, e_vb, e_hl, e_vl;
      string t_in, t_hd, t_vb, t_hl, t_vl;
      m  = k[1:0];
      hn = k[2];
      vn = k[3];
      ho = k[4];
      vo = k[5];
      ha = !hn;
      va = !vn;
      mode = m; h_shift_n = hn; v_shift_n = vn;
      hlim_on_shift = ho; vlim_on_shift = vo;
      @(posedge clk);
      @(negedge clk);
      // expected values from the requirements
      e_hd = ha; t_hd = "R10";
      e_vb = va; t_vb = "R10";
      e_hl = 1'b1; t_hl = "R9";
      e_vl = 1'b1; t_vl = "R9";
      case (m)
        2'b00: begin e_in = 1'b1; t_in = "R2"; end
        2'b01: begin
          e_in = ha; t_in = "R3";
          if (ho) begin e_hl = va; t_hl = "R6"; end
        end
        2'b10: begin
          e_in = va; t_in = "R4";
          if (vo) begin e_vl = ha; t_vl = "R5"; end
        end
        default: begin
          e_in = ha & va; t_in = "R7";
          e_hd = ha & va; t_hd = "R7";
          e_vb = ha & va; t_vb = "R7";
          t_hl = "R8"; t_vl = "R8";
        end
      endcase
      check(t_in, "in_load",   in_load,   e_in);
      check(t_hd, "hdly_load", hdly_load, e_hd);
      check(t_vb, "vbuf_load", vbuf_load, e_vb);
      check(t_hl, "hlim_load", hlim_load, e_hl);
      check(t_vl, "vlim_load", vlim_load, e_vl);
    end

    // R1: latency - a change just after an edge is not visible until the next edge
    mode = 2'b11; h_shift_n = 1'b0; v_shift_n = 1'b0;
    @(posedge clk);
    #1;
    h_shift_n = 1'b1;
    @(negedge clk);
    check("R1", "in_load held one cycle", in_load, 1'b1);
    @(negedge clk);
    check("R1", "in_load after next edge", in_load, 1'b0);

    // R1: reset mid-run clears strobes
    rst = 1'b1;
    @(negedge clk);
    check("R1", "hlim_load after reset", hlim_load, 1'b0);
    check("R1", "vlim_load after reset", vlim_load, 1'b0);
    rst = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule